// File: doc/BRIEF.md
# Iterative Multiplier with Multiply-Accumulate

This block multiplies two 32-bit operands, treated as signed or unsigned, into a 64-bit product. It has only one 16x16 unsigned partial-product array. A multiply turns both operands into magnitudes, feeds the four half-word pairings through the array one after another, and sums the shifted partial products. In the final step it negates the sum when the operand signs differ. A build-time option adds a register inside the array. This shortens the combinational path and adds one cycle of latency.

A second, independent path multiplies the low half-words of the operands in one cycle, signed or unsigned. It adds the 32-bit result into a 40-bit running accumulator. A caller issues work with a one-cycle start strobe while the block is not busy. It then waits for the one-cycle done pulse.

Top module: `imul_mac`

## Requirements
- R1: After a synchronous active-low reset, busy and done are 0, product is 0 and acc is 0.
- R2: With op_mac=0 and is_signed=0, an accepted start yields product = a*b as a 64-bit unsigned value.
- R3: With op_mac=0 and is_signed=1, product is the 64-bit two's-complement product of a and b. This includes the case where both operands are the most negative value.
- R4: A multiply start is accepted on a clock edge where busy is 0. busy is then 1 from that edge on. done and the new product appear after exactly 4 further edges when PIPE_STAGE=0, and after 5 when PIPE_STAGE=1. busy is 0 in the done cycle.
- R5: done is high for exactly one cycle per completed operation. product keeps its value until the next multiply completes.
- R6: A start of either kind that arrives while busy is 1 is ignored. It changes neither the running product nor acc.
- R7: With op_mac=1, an accepted start adds the product of a[15:0] and b[15:0] to acc. The product is sign-extended to 40 bits when is_signed=1 and zero-extended when is_signed=0. acc shows the new value and done pulses one edge later, and busy stays 0.
- R8: acc wraps modulo 2^40.
- R9: acc_clr sets acc to 0 at the next edge. When a MAC is accepted on the same edge, the clear wins, and done still pulses for that MAC.
- R10: A MAC leaves product unchanged, and a multiply leaves acc unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Operation request strobe |
| op_mac | input | 1 | 0 = 32x32 multiply, 1 = 16x16 multiply-accumulate |
| is_signed | input | 1 | 1 = operands are two's complement |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| acc_clr | input | 1 | Synchronous accumulator clear |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 64 | Last 64-bit multiply result |
| acc | output | 40 | Accumulator value |

## Verification
A wrong issue counter or pipeline valid bit shows up at the ports as done arriving one edge early or late. It can also show as a product missing a partial term, and either fault is visible in the very first multiply after reset. A bad magnitude or sign flag shows only for signed operands with a negative input, which is why the vectors include mixed signs and the most negative value. A start that leaks in during busy corrupts the product or acc of that same operation, so it is checked directly at its done pulse.

// File: rtl/imul_pkg.sv
// Package: shared types for the iterative multiplier.
// Assumes operand width is even so it splits into two halves.
package imul_pkg;
    // Selects which half-word pairing the array processes in a step.
    typedef enum logic [1:0] {
        PP_LL = 2'd0,
        PP_LH = 2'd1,
        PP_HL = 2'd2,
        PP_HH = 2'd3
    } pp_sel_e;
endpackage

// File: rtl/imul_core16.sv
// Module: half-width unsigned multiplier array, with an optional register stage.
// Assumes unsigned inputs. With PIPE_STAGE=1 the outputs lag the inputs by one cycle.
module imul_core16 #(
    parameter int H          = 16,
    parameter bit PIPE_STAGE = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vin,
    input  imul_pkg::pp_sel_e  sel_in,
    input  logic [H-1:0]       x,
    input  logic [H-1:0]       y,
    output logic               vout,
    output imul_pkg::pp_sel_e  sel_out,
    output logic [2*H-1:0]     p
);
    localparam int PW = 2 * H;

    logic [PW-1:0] raw;

    // Full-width unsigned product of the two halves.
    always_comb raw = {{H{1'b0}}, x} * {{H{1'b0}}, y};

    generate
        if (PIPE_STAGE) begin : g_pipe
            logic              v_q;
            imul_pkg::pp_sel_e s_q;
            logic [PW-1:0]     p_q;

            // Register the product with its tag and valid bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    s_q <= imul_pkg::PP_LL;
                    p_q <= '0;
                end else begin
                    v_q <= vin;
                    s_q <= sel_in;
                    p_q <= raw;
                end
            end
            assign vout    = v_q;
            assign sel_out = s_q;
            assign p       = p_q;

            // R4: the stage delays valid by exactly one cycle.
            a_r4_pipe_valid: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (vout == $past(vin)));
        end else begin : g_comb
            assign vout    = vin;
            assign sel_out = sel_in;
            assign p       = raw;
        end
    endgenerate
endmodule

// File: rtl/imul_seq.sv
// Module: sequencer for the 32x32 multiply. It sends four half-word pairings
// through the shared array, sums them, and applies the sign at the last step.
// Assumes go is asserted only while busy is low.
module imul_seq #(
    parameter int W          = 32,
    parameter bit PIPE_STAGE = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic           sgn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    import imul_pkg::*;

    localparam int H   = W / 2;
    localparam int P   = 2 * W;
    localparam int LAT = PIPE_STAGE ? 5 : 4;

    logic [W-1:0] mag_a, mag_b;
    logic         neg_q, busy_q, done_q;
    logic [2:0]   iss_q;
    logic [P-1:0] sum_q, prod_q;

    logic         vin, vout;
    pp_sel_e      sel_in, sel_out;
    logic [H-1:0] x, y;
    logic [W-1:0] pp;
    logic [P-1:0] term, total;

    // Issue a step while fewer than four have gone out.
    always_comb begin
        vin    = busy_q && !iss_q[2];
        sel_in = pp_sel_e'(iss_q[1:0]);
        unique case (sel_in)
            PP_LL:   begin x = mag_a[H-1:0]; y = mag_b[H-1:0]; end
            PP_LH:   begin x = mag_a[H-1:0]; y = mag_b[W-1:H]; end
            PP_HL:   begin x = mag_a[W-1:H]; y = mag_b[H-1:0]; end
            default: begin x = mag_a[W-1:H]; y = mag_b[W-1:H]; end
        endcase
    end

    imul_core16 #(.H(H), .PIPE_STAGE(PIPE_STAGE)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .vin     (vin),
        .sel_in  (sel_in),
        .x       (x),
        .y       (y),
        .vout    (vout),
        .sel_out (sel_out),
        .p       (pp)
    );

    // Shift the returning partial product to its weight and add it to the running sum.
    always_comb begin
        unique case (sel_out)
            PP_LL:        term = {{W{1'b0}}, pp};
            PP_LH, PP_HL: term = {{H{1'b0}}, pp, {H{1'b0}}};
            default:      term = {pp, {W{1'b0}}};
        endcase
        total = sum_q + term;
    end

    // Capture the magnitudes on start, count issued steps, accumulate and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_a  <= '0;
            mag_b  <= '0;
            neg_q  <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            iss_q  <= '0;
            sum_q  <= '0;
            prod_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                mag_a  <= (sgn && a[W-1]) ? (~a + 1'b1) : a;
                mag_b  <= (sgn && b[W-1]) ? (~b + 1'b1) : b;
                neg_q  <= sgn && (a[W-1] ^ b[W-1]);
                iss_q  <= '0;
                sum_q  <= '0;
                busy_q <= 1'b1;
            end else begin
                if (vin) iss_q <= iss_q + 3'd1;
                if (vout) begin
                    if (sel_out == PP_HH) begin
                        prod_q <= neg_q ? (~total + 1'b1) : total;
                        done_q <= 1'b1;
                        busy_q <= 1'b0;
                    end else begin
                        sum_q <= total;
                    end
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign product = prod_q;

    // Checker state: edges elapsed since the start was accepted.
    logic [3:0] lat_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_q <= '0;
        else if (go)     lat_q <= '0;
        else if (busy_q) lat_q <= lat_q + 4'd1;
    end

    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (lat_q == 4'(LAT)));
    a_r4_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy_q);
    a_r4_not_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    a_r6_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> ($stable(mag_a) && $stable(mag_b) && $stable(neg_q)));
endmodule

// File: rtl/imul_acc.sv
// Module: single-cycle half-width multiply-accumulate into a wrapping accumulator.
// Assumes ACC_W >= W. A clear takes priority over accumulation.
module imul_acc #(
    parameter int W     = 32,
    parameter int ACC_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             clr,
    input  logic             sgn,
    input  logic [W/2-1:0]   x,
    input  logic [W/2-1:0]   y,
    output logic             done,
    output logic [ACC_W-1:0] acc
);
    localparam int H  = W / 2;
    localparam int XW = ACC_W - W;

    logic [W-1:0]     sp, up;
    logic [ACC_W-1:0] ext, acc_q;
    logic             done_q;

    // Form the signed or unsigned product and widen it to the accumulator width.
    always_comb begin
        sp  = {{H{x[H-1]}}, x} * {{H{y[H-1]}}, y};
        up  = {{H{1'b0}}, x} * {{H{1'b0}}, y};
        ext = sgn ? {{XW{sp[W-1]}}, sp} : {{XW{1'b0}}, up};
    end

    // Clear or accumulate, and flag completion one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= go;
            if (clr)     acc_q <= '0;
            else if (go) acc_q <= acc_q + ext;
        end
    end

    assign acc  = acc_q;
    assign done = done_q;

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));
    a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> done_q);
    a_r10_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !clr) |=> $stable(acc_q));
endmodule

// File: rtl/imul_mac.sv
// Module: top of the iterative multiplier with multiply-accumulate.
// A start is taken only while no multiply is running. op_mac routes it either to
// the sequenced 32x32 multiply or to the single-cycle MAC path.
module imul_mac #(
    parameter int W          = 32,
    parameter int ACC_W      = 40,
    parameter bit PIPE_STAGE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_mac,
    input  logic             is_signed,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic             acc_clr,
    output logic             busy,
    output logic             done,
    output logic [2*W-1:0]   product,
    output logic [ACC_W-1:0] acc
);
    localparam int H = W / 2;

    logic accept, mul_go, mac_go, mul_done, mac_done, mul_busy;

    // Admit a request only when the multiply sequencer is idle.
    always_comb begin
        accept = start && !mul_busy;
        mul_go = accept && !op_mac;
        mac_go = accept && op_mac;
    end

    imul_seq #(.W(W), .PIPE_STAGE(PIPE_STAGE)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (mul_go),
        .sgn     (is_signed),
        .a       (a),
        .b       (b),
        .busy    (mul_busy),
        .done    (mul_done),
        .product (product)
    );

    imul_acc #(.W(W), .ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (mac_go),
        .clr   (acc_clr),
        .sgn   (is_signed),
        .x     (a[H-1:0]),
        .y     (b[H-1:0]),
        .done  (mac_done),
        .acc   (acc)
    );

    assign busy = mul_busy;
    assign done = mul_done | mac_done;

    a_r5_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        !(mul_done && mac_done));
    a_r10_product_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mul_done |-> $stable(product));
endmodule

// File: tb/imul_mac_test.sv
`timescale 1ns/1ps
module imul_mac_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, op_mac, is_signed, acc_clr;
    logic [31:0] a, b;
    logic        busy0, done0, busy1, done1;
    logic [63:0] prod0, prod1;
    logic [39:0] acc0, acc1;

    int total = 0;
    int bad   = 0;
    logic [39:0] acc_model = '0;

    always #2.5 clk = ~clk;

    imul_mac uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_mac(op_mac),
        .is_signed(is_signed), .a(a), .b(b), .acc_clr(acc_clr),
        .busy(busy0), .done(done0), .product(prod0), .acc(acc0));

    imul_mac #(.PIPE_STAGE(1'b1)) uut_p (
        .clk(clk), .rst_n(rst_n), .start(start), .op_mac(op_mac),
        .is_signed(is_signed), .a(a), .b(b), .acc_clr(acc_clr),
        .busy(busy1), .done(done1), .product(prod1), .acc(acc1));

    // Stimulus table: {signed, a, b}.
    localparam int NV = 8;
    localparam logic [64:0] VEC [NV] = '{
        {1'b0, 32'h0000_0000, 32'h1234_5678},
        {1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {1'b1, 32'h8000_0000, 32'h8000_0000},
        {1'b1, 32'h8000_0000, 32'h0000_0001},
        {1'b0, 32'h1234_5678, 32'h9ABC_DEF0},
        {1'b1, 32'h1234_5678, 32'h9ABC_DEF0},
        {1'b0, 32'h0001_0000, 32'h0001_0000}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mul_ref(input logic [31:0] x, input logic [31:0] y, input logic s);
        logic [63:0] xe, ye;
        xe = s ? {{32{x[31]}}, x} : {32'b0, x};
        ye = s ? {{32{y[31]}}, y} : {32'b0, y};
        return xe * ye;
    endfunction

    function automatic logic [39:0] mac_ref(input logic [15:0] x, input logic [15:0] y, input logic s);
        logic [31:0] xe, ye, pr;
        xe = s ? {{16{x[15]}}, x} : {16'b0, x};
        ye = s ? {{16{y[15]}}, y} : {16'b0, y};
        pr = xe * ye;
        return s ? {{8{pr[31]}}, pr} : {8'b0, pr};
    endfunction

    // One multiply on both instances; optionally inject a start while busy.
    task automatic run_mul(input logic [31:0] ta, input logic [31:0] tb, input logic ts, input bit inject);
        logic [63:0] exp;
        exp = mul_ref(ta, tb, ts);
        @(negedge clk);
        start = 1'b1; op_mac = 1'b0; a = ta; b = tb; is_signed = ts;
        @(negedge clk);
        start = 1'b0; a = '0; b = '0;
        check("R4 busy after start", {62'b0, busy1, busy0}, 64'd3);
        for (int k = 1; k <= 5; k++) begin
            if (inject && k == 2) begin
                start = 1'b1; op_mac = 1'b1; a = 32'h7777_0003; b = 32'h5555_0005; is_signed = 1'b0;
            end
            @(negedge clk);
            start = 1'b0; op_mac = 1'b0;
            check("R4 R5 done timing base", {63'b0, done0}, {63'b0, k == 4});
            check("R4 R5 done timing piped", {63'b0, done1}, {63'b0, k == 5});
            if (k == 4) check("R4 busy low at done", {63'b0, busy0}, 64'd0);
        end
        check(ts ? "R3 signed product base" : "R2 unsigned product base", prod0, exp);
        check(ts ? "R3 signed product piped" : "R2 unsigned product piped", prod1, exp);
        check("R10 R6 acc untouched by multiply", {24'b0, acc0}, {24'b0, acc_model});
    endtask

    task automatic run_mac(input logic [15:0] x, input logic [15:0] y, input logic s, input logic clr);
        @(negedge clk);
        start = 1'b1; op_mac = 1'b1; a = {16'hA5A5, x}; b = {16'h5A5A, y}; is_signed = s; acc_clr = clr;
        acc_model = clr ? '0 : acc_model + mac_ref(x, y, s);
        @(negedge clk);
        start = 1'b0; op_mac = 1'b0; acc_clr = 1'b0;
        check("R7 R9 mac done", {62'b0, done1, done0}, 64'd3);
        check("R7 R8 R9 acc value", {24'b0, acc0}, {24'b0, acc_model});
        check("R7 no busy for mac", {63'b0, busy0}, 64'd0);
        @(negedge clk);
        check("R5 R7 done single", {63'b0, done0}, 64'd0);
    endtask

    initial begin
        logic [63:0] held;
        rst_n = 1'b0; start = 1'b0; op_mac = 1'b0; is_signed = 1'b0; acc_clr = 1'b0;
        a = '0; b = '0;
        repeat (3) @(negedge clk);
        check("R1 reset busy done", {60'b0, busy0, done0, busy1, done1}, 64'd0);
        check("R1 reset product", prod0 | prod1, 64'd0);
        check("R1 reset acc", {24'b0, acc0 | acc1}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            run_mul(VEC[i][63:32], VEC[i][31:0], VEC[i][64], 1'b0);

        // R6: a start during busy is ignored.
        run_mul(32'hDEAD_BEEF, 32'h0000_1234, 1'b0, 1'b1);

        // R7 and R10: a MAC leaves the product alone.
        held = prod0;
        run_mac(16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
        run_mac(16'h8000, 16'h7FFF, 1'b1, 1'b0);
        check("R10 product held across mac", prod0, held);

        // R9: clear and MAC on the same edge; clear wins.
        run_mac(16'h0003, 16'h0004, 1'b0, 1'b1);
        check("R9 clear wins", {24'b0, acc0}, 64'd0);

        // R8: wrap below zero and back.
        run_mac(16'hFFFF, 16'h0001, 1'b1, 1'b0);
        check("R8 wrap to all ones", {24'b0, acc0}, {24'b0, 40'hFF_FFFF_FFFF});
        run_mac(16'h0001, 16'h0001, 1'b1, 1'b0);
        check("R8 wrap to zero", {24'b0, acc0}, 64'd0);

        // R9: a standalone clear.
        run_mac(16'h0100, 16'h0100, 1'b0, 1'b0);
        @(negedge clk);
        acc_clr = 1'b1;
        @(negedge clk);
        acc_clr = 1'b0;
        acc_model = '0;
        check("R9 standalone clear", {24'b0, acc0}, 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule